// File: doc/BRIEF.md
# UART Transmit Byte Queue with Watermark

This block sits between a register interface and a UART serializer. Each write strobe deposits the low byte of the write word into a first-in first-out store. The serializer takes bytes from the head through a valid/ready pair, and it can take them only while the transmit-enable control bit is set. The block keeps the full and empty flags and the fill level, and it reports the level in a narrow status field. It also produces the watermark and drain-to-empty indications that an interrupt controller combines with its enable bits.

The watermark is a sticky condition. A push sets it when the resulting fill reaches the programmed threshold. A pop clears it when the fill drops below the threshold or reaches zero. When a pop empties the queue, a one-cycle empty pulse fires. A flush control bit discards all stored bytes in one cycle. A write that meets a full queue is dropped, unless a pop in the same cycle frees a slot.

Top module: `uart_txq`

## Requirements
- R1: Each cycle with `wr_en` high and the queue accepting stores `wr_data[7:0]` as one entry. The upper bits are ignored. Bytes reach `ser_data` in the order they were written.
- R2: A write made while `full` is high, with no pop and no flush in the same cycle, is discarded. The level stays at DEPTH and the stored bytes are unchanged.
- R3: After reset the queue is empty: `empty`=1, `full`=0, `lvl_rpt`=0, `wm_irq`=0, `empty_pulse`=0. `empty` is high exactly when the level is zero.
- R4: `full` is high exactly when the level equals DEPTH, and it falls as soon as the level drops below DEPTH.
- R5: After a cycle with an accepted push, `wm_irq` is 1 if the resulting level is greater than or equal to `thresh`.
- R6: `wm_irq` stays high while pops leave the level at or above `thresh`. It clears in the cycle after a pop brings the level below `thresh`.
- R7: A pop that takes the level to zero raises `empty_pulse` for exactly one cycle, in the cycle after that pop, together with `empty`. It also clears `wm_irq`, even when `thresh` is 0.
- R8: `ser_valid` is high only when `tx_en` is 1 and the queue is not empty. With `tx_en`=0 no byte leaves and the level holds.
- R9: A cycle with `flush`=1 sets the level to zero on the next cycle and clears `wm_irq`. It drops a write made in the same cycle and raises no `empty_pulse`.
- R10: `lvl_rpt` is the level modulo 32, a 5-bit field. At a level of 32 it reads 0 while `full` is 1.
- R11: A push and a pop in the same cycle are both honoured and leave the level unchanged, including when the queue is full. The pushed byte joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | WR_W (32) | Write word; the low 8 bits are queued |
| thresh | input | LVL_W (6) | Watermark threshold |
| flush | input | 1 | Discard all queued bytes |
| tx_en | input | 1 | Transmit enable; gates hand-off to the serializer |
| ser_rdy | input | 1 | Serializer accepts the head byte |
| ser_data | output | 8 | Head byte |
| ser_valid | output | 1 | Head byte available to the serializer |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no byte |
| lvl_rpt | output | RPT_W (5) | Fill level status field |
| wm_irq | output | 1 | Watermark condition |
| empty_pulse | output | 1 | One-cycle pulse on draining to zero |

## Verification
A register write and a serializer hand-off can land on the same clock edge. This case is provoked twice, with the queue fully loaded and with it partly loaded, by raising `wr_en`, `tx_en` and `ser_rdy` for a single cycle. It is judged by checking that the full flag and the level field are unchanged afterwards. A complete drain must then return the old head's successors followed by the new byte, with nothing lost or duplicated. Flush colliding with a write is provoked the same way, and it is judged by a zero level and no valid output afterwards.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef logic [7:0] txq_byte_t;

    // Resolved per-cycle operations on the queue
    typedef struct packed {
        logic flush;
        logic push;
        logic pop;
    } txq_op_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int unsigned lvl_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  txq_op_t   op,
    input  txq_byte_t wbyte,
    output txq_byte_t rbyte
);
    localparam int PTR_W = ptr_bits(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    txq_byte_t        mem [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (op.push) wp_q <= step(wp_q);
            if (op.pop)  rp_q <= step(rp_q);
        end
    end

    always_ff @(posedge clk) begin
        if (op.push) mem[wp_q] <= wbyte;
    end

    assign rbyte = mem[rp_q];

endmodule

// File: rtl/uart_txq_count.sv
module uart_txq_count
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  txq_op_t          op,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nxt,
    output logic             full,
    output logic             empty
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    logic [LVL_W-1:0] lvl_q;
    logic             full_q;
    logic             empty_q;

    always_comb begin
        if (op.flush) level_nxt = '0;
        else          level_nxt = lvl_q + LVL_W'(op.push) - LVL_W'(op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            lvl_q   <= level_nxt;
            full_q  <= (level_nxt == TOP);
            empty_q <= (level_nxt == '0);
        end
    end

    assign level = lvl_q;
    assign full  = full_q;
    assign empty = empty_q;

endmodule

// File: rtl/uart_txq_events.sv
module uart_txq_events
    import uart_txq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  txq_op_t          op,
    input  logic [LVL_W-1:0] level_nxt,
    input  logic [LVL_W-1:0] thresh,
    output logic             wm,
    output logic             drained
);
    logic wm_q;
    logic drained_q;
    logic wm_n;

    always_comb begin
        wm_n = wm_q;
        if (op.flush)
            wm_n = 1'b0;
        else if (op.push && (level_nxt >= thresh))
            wm_n = 1'b1;
        else if (op.pop && ((level_nxt < thresh) || (level_nxt == '0)))
            wm_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q      <= 1'b0;
            drained_q <= 1'b0;
        end else begin
            wm_q      <= wm_n;
            drained_q <= !op.flush && op.pop && (level_nxt == '0);
        end
    end

    assign wm      = wm_q;
    assign drained = drained_q;

endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WR_W  = 32,
    parameter int RPT_W = 5,
    parameter int LVL_W = lvl_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic [LVL_W-1:0] thresh,
    input  logic             flush,
    input  logic             tx_en,
    input  logic             ser_rdy,
    output logic [7:0]       ser_data,
    output logic             ser_valid,
    output logic             full,
    output logic             empty,
    output logic [RPT_W-1:0] lvl_rpt,
    output logic             wm_irq,
    output logic             empty_pulse
);
    txq_op_t          op;
    txq_byte_t        head;
    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_nxt;
    logic             full_w;
    logic             empty_w;

    assign ser_valid = tx_en && !empty_w;

    always_comb begin
        op.flush = flush;
        op.pop   = ser_valid && ser_rdy && !flush;
        op.push  = wr_en && !flush && (!full_w || op.pop);
    end

    generate
        if (WR_W > 8) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^wr_data[WR_W-1:8];
        end
        if (LVL_W >= RPT_W) begin : g_rpt_trunc
            assign lvl_rpt = level_q[RPT_W-1:0];
        end else begin : g_rpt_ext
            assign lvl_rpt = RPT_W'(level_q);
        end
    endgenerate

    uart_txq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wbyte (wr_data[7:0]),
        .rbyte (head)
    );

    uart_txq_count #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .level     (level_q),
        .level_nxt (level_nxt),
        .full      (full_w),
        .empty     (empty_w)
    );

    uart_txq_events #(.LVL_W(LVL_W)) u_events (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .level_nxt (level_nxt),
        .thresh    (thresh),
        .wm        (wm_irq),
        .drained   (empty_pulse)
    );

    assign ser_data = head;
    assign full     = full_w;
    assign empty    = empty_w;

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             flush,
    input logic             tx_en,
    input logic             ser_rdy,
    input logic             ser_valid,
    input logic             full,
    input logic             empty,
    input logic             wm_irq,
    input logic             empty_pulse,
    input logic [LVL_W-1:0] thresh,
    input logic [LVL_W-1:0] level_q
);
    logic popping;
    assign popping = ser_valid && ser_rdy;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !popping && !flush) |=> (full && level_q == LVL_W'(DEPTH)));

    a_r3_empty_flag: assert property (@(posedge clk) disable iff (rst)
        empty == (level_q == '0));

    a_r4_full_flag: assert property (@(posedge clk) disable iff (rst)
        full == (level_q == LVL_W'(DEPTH)));

    a_r5_wm_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !popping && !flush &&
         (int'(level_q) + 1 >= int'(thresh))) |=> wm_irq);

    a_r7_pulse_empty: assert property (@(posedge clk) disable iff (rst)
        empty_pulse |-> (empty && !wm_irq));

    a_r8_gated: assert property (@(posedge clk) disable iff (rst)
        (!tx_en || empty) |-> !ser_valid);

    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level_q == '0 && !wm_irq && !empty_pulse));

    a_r11_both: assert property (@(posedge clk) disable iff (rst)
        (wr_en && popping && !flush) |=> (level_q == $past(level_q)));

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .flush       (flush),
    .tx_en       (tx_en),
    .ser_rdy     (ser_rdy),
    .ser_valid   (ser_valid),
    .full        (full),
    .empty       (empty),
    .wm_irq      (wm_irq),
    .empty_pulse (empty_pulse),
    .thresh      (thresh),
    .level_q     (level_q)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  thresh = '0;
    logic        flush = 1'b0;
    logic        tx_en = 1'b0;
    logic        ser_rdy = 1'b0;
    logic [7:0]  ser_data;
    logic        ser_valid, full, empty, wm_irq, empty_pulse;
    logic [4:0]  lvl_rpt;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got [64];
    int n_got;
    int n_pulse;

    always #2 clk = ~clk;

    uart_txq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .thresh(thresh),
        .flush(flush), .tx_en(tx_en), .ser_rdy(ser_rdy), .ser_data(ser_data),
        .ser_valid(ser_valid), .full(full), .empty(empty), .lvl_rpt(lvl_rpt),
        .wm_irq(wm_irq), .empty_pulse(empty_pulse)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_one();
        tx_en = 1'b1; ser_rdy = 1'b1;
        @(negedge clk);
        tx_en = 1'b0; ser_rdy = 1'b0;
    endtask

    task automatic drain();
        n_got = 0; n_pulse = 0;
        tx_en = 1'b1; ser_rdy = 1'b1;
        #1;
        for (int c = 0; c < 100; c++) begin
            if (ser_valid) begin got[n_got] = ser_data; n_got++; end
            @(negedge clk);
            if (empty_pulse) n_pulse++;
            if (empty && !ser_valid) break;
        end
        @(negedge clk);
        if (empty_pulse) n_pulse++;
        tx_en = 1'b0; ser_rdy = 1'b0;
    endtask

    task automatic t_reset();
        chk(empty == 1'b1, "R3 empty after reset", int'(empty), 1);
        chk(full == 1'b0, "R3 full after reset", int'(full), 0);
        chk(lvl_rpt == 5'd0, "R3 level after reset", int'(lvl_rpt), 0);
        chk(wm_irq == 1'b0 && empty_pulse == 1'b0, "R3 events after reset",
            int'({wm_irq, empty_pulse}), 0);
    endtask

    task automatic t_order();
        thresh = 6'd20;
        push(32'hABCD_EF11); push(32'h1234_5622); push(32'hFFFF_FF33);
        chk(lvl_rpt == 5'd3, "R10 level three", int'(lvl_rpt), 3);
        chk(empty == 1'b0, "R3 empty clears", int'(empty), 0);
        repeat (4) @(negedge clk);
        chk(ser_valid == 1'b0, "R8 no valid while disabled", int'(ser_valid), 0);
        chk(lvl_rpt == 5'd3, "R8 level holds while disabled", int'(lvl_rpt), 3);
        drain();
        chk(n_got == 3, "R1 byte count", n_got, 3);
        chk(got[0] == 8'h11, "R1 byte 0 low bits", int'(got[0]), 'h11);
        chk(got[1] == 8'h22, "R1 byte 1", int'(got[1]), 'h22);
        chk(got[2] == 8'h33, "R1 byte 2", int'(got[2]), 'h33);
        chk(n_pulse == 1, "R7 single empty pulse", n_pulse, 1);
        chk(empty == 1'b1, "R3 empty after drain", int'(empty), 1);
    endtask

    task automatic t_fill_overflow();
        thresh = 6'd40;
        for (int i = 0; i < 32; i++) push(32'(i));
        chk(full == 1'b1, "R4 full at depth", int'(full), 1);
        chk(lvl_rpt == 5'd0, "R10 field wraps at depth", int'(lvl_rpt), 0);
        push(32'h0000_00EE);
        chk(full == 1'b1 && lvl_rpt == 5'd0, "R2 overflow write dropped",
            int'(lvl_rpt), 0);
        pop_one();
        chk(full == 1'b0, "R4 full clears below depth", int'(full), 0);
        chk(lvl_rpt == 5'd31, "R10 level 31", int'(lvl_rpt), 31);
        drain();
        chk(n_got == 31, "R2 count after overflow", n_got, 31);
        for (int i = 0; i < 31; i++)
            chk(got[i] == 8'(i + 1), "R2 stored bytes intact", int'(got[i]), i + 1);
    endtask

    task automatic t_watermark();
        thresh = 6'd4;
        push(1); push(2); push(3);
        chk(wm_irq == 1'b0, "R5 below threshold", int'(wm_irq), 0);
        push(4);
        chk(wm_irq == 1'b1, "R5 set at threshold", int'(wm_irq), 1);
        push(5);
        pop_one();
        chk(wm_irq == 1'b1, "R6 holds at threshold", int'(wm_irq), 1);
        pop_one();
        chk(wm_irq == 1'b0, "R6 clears below threshold", int'(wm_irq), 0);
        drain();
        chk(n_pulse == 1 && empty == 1'b1, "R7 pulse on drain", n_pulse, 1);
        thresh = 6'd0;
        push(9);
        chk(wm_irq == 1'b1, "R5 zero threshold sets", int'(wm_irq), 1);
        tx_en = 1'b1; ser_rdy = 1'b1;
        @(negedge clk);
        tx_en = 1'b0; ser_rdy = 1'b0;
        chk(empty_pulse == 1'b1, "R7 pulse in cycle after last pop", int'(empty_pulse), 1);
        chk(wm_irq == 1'b0, "R7 watermark cleared at zero", int'(wm_irq), 0);
        @(negedge clk);
        chk(empty_pulse == 1'b0, "R7 pulse one cycle wide", int'(empty_pulse), 0);
    endtask

    task automatic t_flush();
        thresh = 6'd2;
        push(7); push(8); push(9);
        chk(wm_irq == 1'b1, "R5 set before flush", int'(wm_irq), 1);
        flush = 1'b1; wr_en = 1'b1; wr_data = 32'h55;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        chk(lvl_rpt == 5'd0 && empty == 1'b1, "R9 level zero after flush", int'(lvl_rpt), 0);
        chk(wm_irq == 1'b0, "R9 watermark cleared", int'(wm_irq), 0);
        chk(empty_pulse == 1'b0, "R9 no empty pulse", int'(empty_pulse), 0);
        tx_en = 1'b1; #1;
        chk(ser_valid == 1'b0, "R9 write during flush dropped", int'(ser_valid), 0);
        @(negedge clk);
        tx_en = 1'b0;
    endtask

    task automatic t_simul();
        thresh = 6'd40;
        for (int i = 0; i < 32; i++) push(32'(8'h80 + i));
        tx_en = 1'b1; ser_rdy = 1'b1; wr_en = 1'b1; wr_data = 32'h77;
        @(negedge clk);
        tx_en = 1'b0; ser_rdy = 1'b0; wr_en = 1'b0;
        chk(full == 1'b1 && lvl_rpt == 5'd0, "R11 full level unchanged",
            int'(full), 1);
        drain();
        chk(n_got == 32, "R11 count after full push+pop", n_got, 32);
        chk(got[0] == 8'h81, "R11 head advanced", int'(got[0]), 'h81);
        chk(got[31] == 8'h77, "R11 pushed byte at tail", int'(got[31]), 'h77);
        push(32'hA0); push(32'hA1); push(32'hA2);
        tx_en = 1'b1; ser_rdy = 1'b1; wr_en = 1'b1; wr_data = 32'hA3;
        @(negedge clk);
        tx_en = 1'b0; ser_rdy = 1'b0; wr_en = 1'b0;
        chk(lvl_rpt == 5'd3, "R11 partial level unchanged", int'(lvl_rpt), 3);
        drain();
        chk(n_got == 3 && got[0] == 8'hA1 && got[2] == 8'hA3, "R11 partial order",
            int'(got[2]), 'hA3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_fill_overflow();
        t_watermark();
        t_flush();
        t_simul();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule